// File: doc/BRIEF.md
# Multichannel Output Sequencer Formatter

This block gathers I, Q and AGC-gain words from up to four processing channels and serialises them onto a single 16-bit parallel output bus, one word per clock, in an order set by a slot table. Each slot names a channel and a word kind. A frame begins only when every channel named by an active slot has delivered a fresh sample since its last frame. The first word of every frame is marked by a one-clock frame sync, and an output-enable flag is high on every clock that carries frame data.

Two output options are provided. With inversion enabled, every word driven during a frame is the ones' complement of the selected word. With split mode enabled, the bus acts as two 8-bit lanes. Each clock then carries the upper bytes of two consecutive slots, so a frame takes half as many clocks.

The sample side is a pulse interface with no ready: a channel's sample-ready pulse always lands, and a sample that replaces one not yet sent raises a sticky overrun flag. The output side is a valid-only stream with no back-pressure. The consumer must take each word in the clock in which `out_valid` is high, and the block never stalls a frame once it has begun.

Top module: `mux_frame_sequencer`

## Requirements
- R1: During reset and after it, until a frame starts, `out_valid`, `out_fsync` and `overrun` are 0 and `out_data` is 0.
- R2: A frame starts only when every channel named by slots 0..count-1 has a pending fresh sample. Unnamed channels are not waited for, and a count of 0 starts no frame. The first word appears in the clock after the edge that captures the last needed sample.
- R3: Words are driven one per clock in slot order. Slot k takes its channel from `cfg_slot_chan[2k+1:2k]` and its kind from `cfg_slot_kind[2k+1:2k]`, where 0 = I, 1 = Q, 2 = gain and 3 = an all-zero word. A count above 8 acts as 8.
- R4: `out_fsync` is 1 exactly in the clock that carries the first word of a frame, and it is never 1 while `out_valid` is 0.
- R5: With `cfg_invert` = 1, every word driven during a frame is the bitwise ones' complement of the word that would otherwise be driven.
- R6: With `cfg_split` = 1, clock t of a frame carries the upper byte of slot 2t on bits [15:8] and the upper byte of slot 2t+1 on bits [7:0]. A frame lasts ceil(count/2) clocks. A missing odd final slot contributes 0x00 before inversion.
- R7: A sample pulse for a channel whose previous sample is still pending replaces that sample, and it sets `overrun`, which then stays 1 until reset.
- R8: If all needed samples are pending by the final clock of a frame, the next frame follows with no idle clock in between. A sample arriving in the same clock as a frame start is kept for the next frame.
- R9: Outside a frame, `out_valid` is 0 and `out_data` is 0, whatever `cfg_invert` is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 4 | Per-channel sample-ready pulse |
| smp_i | input | 64 | I words, channel c at [16c+15:16c] |
| smp_q | input | 64 | Q words, channel c at [16c+15:16c] |
| smp_gain | input | 64 | Gain words, channel c at [16c+15:16c] |
| cfg_slot_chan | input | 16 | Channel number of each slot, 2 bits per slot |
| cfg_slot_kind | input | 16 | Word kind of each slot, 2 bits per slot |
| cfg_slot_count | input | 4 | Number of active slots |
| cfg_invert | input | 1 | Drive the ones' complement of frame words |
| cfg_split | input | 1 | Two 8-bit lanes per clock |
| out_data | output | 16 | Output bus |
| out_valid | output | 1 | Output enable, high on frame clocks |
| out_fsync | output | 1 | Frame sync on the first word |
| overrun | output | 1 | Sticky sample-overwrite flag |

## Verification
The slot table is driven with several configurations. These cover one channel carrying all three kinds, all four channels in a reversed order, a single-slot table, a slot of kind 3, an inverted table, and split tables of even and odd length. Together they tell apart errors in channel selection, kind decoding, byte-lane placement and the point at which the complement is applied. Directed tests then hold back one needed channel, program a count of zero, feed a sample in the middle of a frame to test back-to-back framing, and overwrite a pending sample. These separate the start condition, the handling of consumed samples and the overrun flag.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    KIND_I    = 2'd0,
    KIND_Q    = 2'd1,
    KIND_GAIN = 2'd2,
    KIND_NONE = 2'd3
  } word_kind_e;

  typedef struct packed {
    logic [WORD_W-1:0] i_w;
    logic [WORD_W-1:0] q_w;
    logic [WORD_W-1:0] g_w;
  } chan_sample_t;
endpackage

// File: rtl/seq_capture.sv
module seq_capture
  import seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          smp_valid,
  input  logic [NCH*WORD_W-1:0]   smp_i,
  input  logic [NCH*WORD_W-1:0]   smp_q,
  input  logic [NCH*WORD_W-1:0]   smp_gain,
  input  logic [NCH-1:0]          take_mask,
  output chan_sample_t [NCH-1:0]  hold_o,
  output logic [NCH-1:0]          pending_o,
  output logic                    overrun_o
);
  chan_sample_t hold_q [NCH];
  logic         pend_q [NCH];
  logic [NCH-1:0] ovr_hit;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[c] <= '0;
        pend_q[c] <= 1'b0;
      end else begin
        if (smp_valid[c]) begin
          hold_q[c] <= '{i_w: smp_i[c*WORD_W +: WORD_W],
                         q_w: smp_q[c*WORD_W +: WORD_W],
                         g_w: smp_gain[c*WORD_W +: WORD_W]};
          pend_q[c] <= 1'b1;
        end else if (take_mask[c]) begin
          pend_q[c] <= 1'b0;
        end
      end
    end
    assign hold_o[c]    = hold_q[c];
    assign pending_o[c] = pend_q[c];
    assign ovr_hit[c]   = smp_valid[c] & pend_q[c] & ~take_mask[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun_o <= 1'b0;
    else        overrun_o <= overrun_o | (|ovr_hit);
  end
endmodule

// File: rtl/seq_sched.sv
module seq_sched #(
  parameter int NCH   = 4,
  parameter int SLOTS = 8,
  localparam int CW   = $clog2(NCH),
  localparam int SW   = $clog2(SLOTS),
  localparam int IW   = SW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      pending,
  input  logic [SLOTS*CW-1:0] cfg_slot_chan,
  input  logic [IW-1:0]       eff_count,
  input  logic                split,
  output logic                busy,
  output logic [IW-1:0]       idx,
  output logic                start,
  output logic [NCH-1:0]      take_mask
);
  logic [NCH-1:0] needed;
  logic [IW:0]    step;
  logic [IW:0]    nxt;
  logic           last;

  always_comb begin
    needed = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (IW'(k) < eff_count) begin
        needed[cfg_slot_chan[k*CW +: CW]] = 1'b1;
      end
    end
  end

  assign step      = split ? (IW+1)'(2) : (IW+1)'(1);
  assign nxt       = {1'b0, idx} + step;
  assign last      = busy && (nxt >= {1'b0, eff_count});
  assign start     = (|needed) && ((pending & needed) == needed) && (!busy || last);
  assign take_mask = start ? needed : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (last) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      idx  <= nxt[IW-1:0];
    end
  end
endmodule

// File: rtl/seq_format.sv
module seq_format
  import seq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SLOTS = 8,
  localparam int CW   = $clog2(NCH),
  localparam int SW   = $clog2(SLOTS),
  localparam int IW   = SW + 1,
  localparam int HALF = WORD_W / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  chan_sample_t [NCH-1:0] hold_i,
  input  logic                   busy,
  input  logic [IW-1:0]          idx,
  input  logic [IW-1:0]          eff_count,
  input  logic [SLOTS*CW-1:0]    cfg_slot_chan,
  input  logic [SLOTS*2-1:0]     cfg_slot_kind,
  input  logic                   invert,
  input  logic                   split,
  output logic [WORD_W-1:0]      out_data
);
  chan_sample_t      frame_q [NCH];
  logic [WORD_W-1:0] slot_word [SLOTS];
  logic [WORD_W-1:0] cur_w, nxt_w, raw_w;
  logic [IW:0]       nidx;

  for (genvar c = 0; c < NCH; c++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    frame_q[c] <= '0;
      else if (load) frame_q[c] <= hold_i[c];
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [CW-1:0] ch;
    word_kind_e    kd;
    assign ch = cfg_slot_chan[k*CW +: CW];
    assign kd = word_kind_e'(cfg_slot_kind[k*2 +: 2]);
    always_comb begin
      case (kd)
        KIND_I:    slot_word[k] = frame_q[ch].i_w;
        KIND_Q:    slot_word[k] = frame_q[ch].q_w;
        KIND_GAIN: slot_word[k] = frame_q[ch].g_w;
        default:   slot_word[k] = '0;
      endcase
    end
  end

  assign nidx  = {1'b0, idx} + (IW+1)'(1);
  assign cur_w = (idx < eff_count) ? slot_word[idx[SW-1:0]] : '0;
  assign nxt_w = (nidx < {1'b0, eff_count}) ? slot_word[nidx[SW-1:0]] : '0;
  assign raw_w = split ? {cur_w[WORD_W-1 -: HALF], nxt_w[WORD_W-1 -: HALF]} : cur_w;

  assign out_data = busy ? (raw_w ^ {WORD_W{invert}}) : '0;
endmodule

// File: rtl/mux_frame_sequencer.sv
module mux_frame_sequencer
  import seq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SLOTS = 8,
  localparam int CW   = $clog2(NCH),
  localparam int SW   = $clog2(SLOTS),
  localparam int IW   = SW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        smp_valid,
  input  logic [NCH*WORD_W-1:0] smp_i,
  input  logic [NCH*WORD_W-1:0] smp_q,
  input  logic [NCH*WORD_W-1:0] smp_gain,
  input  logic [SLOTS*CW-1:0]   cfg_slot_chan,
  input  logic [SLOTS*2-1:0]    cfg_slot_kind,
  input  logic [IW-1:0]         cfg_slot_count,
  input  logic                  cfg_invert,
  input  logic                  cfg_split,
  output logic [WORD_W-1:0]     out_data,
  output logic                  out_valid,
  output logic                  out_fsync,
  output logic                  overrun
);
  chan_sample_t [NCH-1:0] hold;
  logic [NCH-1:0]         pending;
  logic [NCH-1:0]         take_mask;
  logic [IW-1:0]          eff_count;
  logic [IW-1:0]          idx;
  logic                   busy;
  logic                   start;

  assign eff_count = (cfg_slot_count > IW'(SLOTS)) ? IW'(SLOTS) : cfg_slot_count;

  seq_capture #(.NCH(NCH)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_i     (smp_i),
    .smp_q     (smp_q),
    .smp_gain  (smp_gain),
    .take_mask (take_mask),
    .hold_o    (hold),
    .pending_o (pending),
    .overrun_o (overrun)
  );

  seq_sched #(.NCH(NCH), .SLOTS(SLOTS)) u_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .pending       (pending),
    .cfg_slot_chan (cfg_slot_chan),
    .eff_count     (eff_count),
    .split         (cfg_split),
    .busy          (busy),
    .idx           (idx),
    .start         (start),
    .take_mask     (take_mask)
  );

  seq_format #(.NCH(NCH), .SLOTS(SLOTS)) u_fmt (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (start),
    .hold_i        (hold),
    .busy          (busy),
    .idx           (idx),
    .eff_count     (eff_count),
    .cfg_slot_chan (cfg_slot_chan),
    .cfg_slot_kind (cfg_slot_kind),
    .invert        (cfg_invert),
    .split         (cfg_split),
    .out_data      (out_data)
  );

  assign out_valid = busy;
  assign out_fsync = busy && (idx == '0);
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int SLOTS = 8,
  localparam int IW   = $clog2(SLOTS) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   out_data,
  input logic          out_valid,
  input logic          out_fsync,
  input logic          overrun,
  input logic [IW-1:0] cfg_slot_count,
  input logic          cfg_split
);
  logic [IW-1:0] eff;
  logic [IW-1:0] frame_clks;

  assign eff        = (cfg_slot_count > IW'(SLOTS)) ? IW'(SLOTS) : cfg_slot_count;
  assign frame_clks = cfg_split ? IW'((eff + IW'(1)) >> 1) : eff;

  AST_SYNC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_fsync |-> out_valid); // R4
  AST_FRAME_OPENS_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_fsync); // R4
  AST_SYNC_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fsync && frame_clks > IW'(1)) |=> (out_valid && !out_fsync)); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == 16'h0000)); // R9
endmodule

bind mux_frame_sequencer seq_checker #(.SLOTS(SLOTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .out_data       (out_data),
  .out_valid      (out_valid),
  .out_fsync      (out_fsync),
  .overrun        (overrun),
  .cfg_slot_count (cfg_slot_count),
  .cfg_split      (cfg_split)
);

// File: tb/tb_mux_frame_sequencer.sv
`timescale 1ns/1ps
module tb_mux_frame_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  smp_valid = '0;
  logic [63:0] smp_i = '0, smp_q = '0, smp_gain = '0;
  logic [15:0] cfg_slot_chan = '0, cfg_slot_kind = '0;
  logic [3:0]  cfg_slot_count = '0;
  logic        cfg_invert = 1'b0, cfg_split = 1'b0;
  logic [15:0] out_data;
  logic        out_valid, out_fsync, overrun;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mux_frame_sequencer dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .smp_gain(smp_gain),
    .cfg_slot_chan(cfg_slot_chan), .cfg_slot_kind(cfg_slot_kind),
    .cfg_slot_count(cfg_slot_count), .cfg_invert(cfg_invert),
    .cfg_split(cfg_split), .out_data(out_data), .out_valid(out_valid),
    .out_fsync(out_fsync), .overrun(overrun)
  );

  typedef struct packed {
    logic [15:0] chans;
    logic [15:0] kinds;
    logic [3:0]  cnt;
    logic        inv;
    logic        spl;
    logic [3:0]  mask;
    logic [3:0]  clks;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0024, 4'd3, 1'b0, 1'b0, 4'b0001, 4'd3},
    '{16'h1B1B, 16'h5500, 4'd8, 1'b0, 1'b0, 4'b1111, 4'd8},
    '{16'h0006, 16'h0002, 4'd2, 1'b1, 1'b0, 4'b0110, 4'd2},
    '{16'h00F5, 16'h0044, 4'd4, 1'b0, 1'b1, 4'b1010, 4'd2},
    '{16'h0008, 16'h0006, 4'd3, 1'b1, 1'b1, 4'b0101, 4'd2},
    '{16'h000F, 16'h0003, 4'd2, 1'b0, 1'b0, 4'b1000, 4'd2},
    '{16'h0001, 16'h0001, 4'd1, 1'b0, 1'b0, 4'b0010, 4'd1}
  };

  function automatic logic [15:0] samp(int c, int kind, int n);
    logic [3:0] cc = 4'(c);
    logic [7:0] nn = 8'(n);
    case (kind)
      0: return {cc, 4'h1, nn};
      1: return {cc, 4'h2, nn};
      2: return {cc, 4'h3, nn};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] slotw(vec_t v, int k, int n);
    if (k >= int'(v.cnt)) return 16'h0000;
    return samp(int'(v.chans[k*2 +: 2]), int'(v.kinds[k*2 +: 2]), n);
  endfunction

  function automatic logic [15:0] exp_bus(vec_t v, int t, int n);
    logic [15:0] a, b, w;
    if (v.spl) begin
      a = slotw(v, 2*t, n);
      b = slotw(v, 2*t+1, n);
      w = {a[15:8], b[15:8]};
    end else begin
      w = slotw(v, t, n);
    end
    return w ^ {16{v.inv}};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(vec_t v);
    cfg_slot_chan  = v.chans;
    cfg_slot_kind  = v.kinds;
    cfg_slot_count = v.cnt;
    cfg_invert     = v.inv;
    cfg_split      = v.spl;
  endtask

  task automatic drive(logic [3:0] mask, int n);
    for (int c = 0; c < 4; c++) begin
      smp_i[c*16 +: 16]    = samp(c, 0, n);
      smp_q[c*16 +: 16]    = samp(c, 1, n);
      smp_gain[c*16 +: 16] = samp(c, 2, n);
    end
    smp_valid = mask;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    vec_t v;
    @(negedge clk);
    chk("R1 valid in reset", {15'd0, out_valid}, 16'd0);
    chk("R1 data in reset", out_data, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {15'd0, out_valid}, 16'd0);
    chk("R1 fsync after reset", {15'd0, out_fsync}, 16'd0);
    chk("R1 overrun after reset", {15'd0, overrun}, 16'd0);

    // table walk: R3 order and kinds, R4 sync, R5 invert, R6 split, R9 idle
    for (int vi = 0; vi < NV; vi++) begin
      v = VECS[vi];
      set_cfg(v);
      drive(v.mask, vi + 1);
      @(negedge clk);
      smp_valid = '0;
      @(negedge clk);
      for (int t = 0; t < int'(v.clks); t++) begin
        chk("R2 frame valid", {15'd0, out_valid}, 16'd1);
        chk("R4 fsync position", {15'd0, out_fsync}, {15'd0, t == 0});
        chk("R3/R5/R6 word", out_data, exp_bus(v, t, vi + 1));
        @(negedge clk);
      end
      chk("R9 idle after frame", {out_valid, out_data[14:0]}, 16'd0);
    end

    // R2: one needed channel withheld
    v = VECS[1];
    set_cfg(v);
    drive(4'b0111, 20);
    @(negedge clk);
    smp_valid = '0;
    repeat (3) @(negedge clk);
    chk("R2 waits for missing channel", {15'd0, out_valid}, 16'd0);
    drive(4'b1000, 20);
    @(negedge clk);
    smp_valid = '0;
    @(negedge clk);
    chk("R2 starts when complete", {15'd0, out_fsync}, 16'd1);
    chk("R2 first word", out_data, exp_bus(v, 0, 20));
    repeat (8) @(negedge clk);

    // R8: back-to-back frames, slots ch0 I,Q,G,I
    v = '{16'h0000, 16'h0024, 4'd4, 1'b0, 1'b0, 4'b0001, 4'd4};
    set_cfg(v);
    drive(4'b0001, 30);
    @(negedge clk);
    smp_valid = '0;
    @(negedge clk);
    chk("R8 frame A sync", {15'd0, out_fsync}, 16'd1);
    @(negedge clk);
    drive(4'b0001, 31);
    @(negedge clk);
    smp_valid = '0;
    @(negedge clk);
    chk("R8 frame A last word", out_data, exp_bus(v, 3, 30));
    @(negedge clk);
    chk("R8 no gap valid", {15'd0, out_valid}, 16'd1);
    chk("R8 no gap sync", {15'd0, out_fsync}, 16'd1);
    chk("R8 frame B first word", out_data, exp_bus(v, 0, 31));
    repeat (5) @(negedge clk);
    chk("R8 idle after B", {15'd0, out_valid}, 16'd0);

    // R7: overwrite while pending, slots ch0 I, ch1 I
    v = '{16'h0004, 16'h0000, 4'd2, 1'b0, 1'b0, 4'b0011, 4'd2};
    set_cfg(v);
    drive(4'b0001, 40);
    @(negedge clk);
    drive(4'b0001, 41);
    chk("R7 no overrun on first", {15'd0, overrun}, 16'd0);
    @(negedge clk);
    smp_valid = '0;
    chk("R7 overrun set", {15'd0, overrun}, 16'd1);
    chk("R7 no frame yet", {15'd0, out_valid}, 16'd0);
    drive(4'b0010, 41);
    @(negedge clk);
    smp_valid = '0;
    @(negedge clk);
    chk("R7 newer sample kept", out_data, exp_bus(v, 0, 41));
    repeat (4) @(negedge clk);
    chk("R7 overrun sticky", {15'd0, overrun}, 16'd1);

    // R2: count of zero starts nothing; R9 idle with invert set
    v = '{16'h0000, 16'h0000, 4'd0, 1'b1, 1'b0, 4'b1111, 4'd0};
    set_cfg(v);
    drive(4'b1111, 50);
    @(negedge clk);
    smp_valid = '0;
    repeat (3) @(negedge clk);
    chk("R2 count zero no frame", {15'd0, out_valid}, 16'd0);
    chk("R9 idle data with invert", out_data, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule